// File: doc/BRIEF.md
# Bidirectional Nibble I/O Port Bank

This block gives a small controller five 4-bit general-purpose pin groups. Each group owns three writable registers: a direction register, an output data register and a pull-up register. They sit on a simple register bus with an address, a 4-bit write value, a write strobe and a combinational read value. Toward the pads the block drives a per-pin output enable, output value and pull-up enable, and it takes the sampled pad levels back in.

How each group drives its pins is fixed when the block is built. Every group is either push-pull or N-channel open-drain. One group, the split group, picks the output type bit by bit instead. A run-time serial enable hands the four pins of the serial group to a serial engine that lives outside this block. Those pins then follow a fixed mapping, whatever the group's own direction and data registers hold. The serial clock pin is driven only when the engine is the master. The ready pin is driven only when the engine is a slave.

Top module: `nib_port_bank`

## Requirements
- R1: After reset every direction bit is 0, every data bit is 1 and every pull-up bit is 1. So with the serial enable low, pad_oe is all 0 and pad_pu is all 1.
- R2: The direction register of port p is at address 0xB0 + 4*p (0xB0, 0xB4, 0xB8, 0xBC, 0xC0). Its data register is one address above that and its pull-up register is two above. A write changes only the addressed register. Reads of the direction and pull-up addresses return the register.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. On a push-pull output pin, pad_oe is 1 and pad_out equals the data bit. pad_out carries meaning only where pad_oe is 1.
- R4: An open-drain output pin with data bit 0 has pad_oe 1 and pad_out 0. With data bit 1 it has pad_oe 0. With the default options, port 1 (pins 7:4) is open-drain.
- R5: On the split group (port 3, pins 15:12) the output type is chosen per bit. With the default options, bits 0 and 2 are open-drain and bits 1 and 3 are push-pull.
- R6: Reading a data address returns, bit by bit, the data register where the direction bit is 1 and the pad input where it is 0.
- R7: When ser_en is 1, port 4 bit 0 (pin 16) is an input and ser_sin follows it. Bit 1 (pin 17) is always driven with ser_sout. When ser_en is 0, ser_sin, ser_sclk_in and ser_rdy_in are 1.
- R8: When ser_en is 1, port 4 bit 2 (pin 18) is driven with ser_sclk_out only while ser_master is 1. Otherwise the pin is an input and ser_sclk_in follows it.
- R9: When ser_en is 1, port 4 bit 3 (pin 19) is driven with ser_rdy_out only while ser_master is 0. Otherwise the pin is an input and ser_rdy_in follows it.
- R10: A write to any address that does not map to a register changes nothing, and a read of such an address returns 0. This covers offsets 3 within a port's four-address window and addresses outside 0xB0..0xC2.
- R11: pad_pu equals the pull-up register bits of each pin. It changes only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 4 | Write value |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_rdata | output | 4 | Combinational read value for bus_addr |
| pad_in | input | 20 | Sampled pad levels, pin 4*p+b is port p bit b |
| pad_oe | output | 20 | Per-pin output enable |
| pad_out | output | 20 | Per-pin output value |
| pad_pu | output | 20 | Per-pin pull-up enable |
| ser_en | input | 1 | Hands port 4 to the serial engine |
| ser_master | input | 1 | Serial engine is the clock master |
| ser_sout | input | 1 | Serial data to send |
| ser_sclk_out | input | 1 | Serial clock from the engine (master mode) |
| ser_rdy_out | input | 1 | Ready from the engine (slave mode) |
| ser_sin | output | 1 | Serial data received from pin 16 |
| ser_sclk_in | output | 1 | Serial clock from pin 18 |
| ser_rdy_in | output | 1 | Ready from pin 19 |

## Verification
The hardest case is the serial handover. The serial group's own direction and data registers must be loaded with values that would fight the fixed mapping, and then both serial roles must be tried while those registers stay untouched. To get there, the stimulus first writes all ones to the port 4 direction register and a chosen data pattern. It then raises the serial enable, flips between master and slave, and finally drops the enable to show that the register-driven behaviour comes back. The open-drain rules are reached by writing complementary data patterns to the open-drain group and to the split group with all pins set as outputs.

// File: rtl/nib_port_pkg.sv
package nib_port_pkg;

  typedef enum logic [1:0] {
    KIND_DIR  = 2'd0,
    KIND_DAT  = 2'd1,
    KIND_PUP  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    logic [7:0] port;
    reg_kind_e kind;
  } dec_t;

  typedef struct packed {
    logic oe;
    logic out;
  } pin_t;

  // Map an address onto (port, register kind); offsets 3.. of each window are holes.
  function automatic dec_t decode(input int addr, input int base, input int stride,
                                  input int nport);
    dec_t d;
    int   off;
    d      = '0;
    d.kind = KIND_NONE;
    off    = addr - base;
    if (off >= 0 && off < stride * nport && (off % stride) < 3) begin
      d.hit  = 1'b1;
      d.port = 8'(off / stride);
      d.kind = reg_kind_e'(2'(off % stride));
    end
    return d;
  endfunction

  // Shape a pin: push-pull passes the value, open-drain only pulls low.
  function automatic pin_t shape(input logic drive, input logic val, input logic od);
    pin_t p;
    if (od) begin
      p.oe  = drive & ~val;
      p.out = 1'b0;
    end else begin
      p.oe  = drive;
      p.out = val;
    end
    return p;
  endfunction

  // Merge register data and pad levels for a data read.
  function automatic logic [3:0] merge_read(input logic [3:0] dir, input logic [3:0] dat,
                                            input logic [3:0] pad);
    return (dir & dat) | (~dir & pad);
  endfunction

endpackage

// File: rtl/nib_port_regs.sv
module nib_port_regs
  import nib_port_pkg::*;
#(
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  reg_kind_e      kind,
  input  logic [NIB-1:0] wdata,
  output logic [NIB-1:0] dir_q,
  output logic [NIB-1:0] dat_q,
  output logic [NIB-1:0] pup_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '1;
      pup_q <= '1;
    end else if (wr_en) begin
      case (kind)
        KIND_DIR: dir_q <= wdata;
        KIND_DAT: dat_q <= wdata;
        KIND_PUP: pup_q <= wdata;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/nib_pin_drive.sv
module nib_pin_drive
  import nib_port_pkg::*;
#(
  parameter int             NIB     = 4,
  parameter logic [NIB-1:0] OD_BITS = '0,
  parameter bit             SER     = 1'b0
) (
  input  logic [NIB-1:0] dir,
  input  logic [NIB-1:0] dat,
  input  logic           ser_en,
  input  logic           ser_master,
  input  logic           ser_sout,
  input  logic           ser_sclk,
  input  logic           ser_rdy,
  output logic [NIB-1:0] oe,
  output logic [NIB-1:0] out
);

  logic take_over;
  assign take_over = SER && ser_en;

  always_comb begin
    for (int b = 0; b < NIB; b++) begin
      logic drive;
      logic val;
      pin_t pin;
      drive = dir[b];
      val   = dat[b];
      if (take_over) begin
        case (b)
          0:       begin drive = 1'b0;        val = 1'b0;     end
          1:       begin drive = 1'b1;        val = ser_sout; end
          2:       begin drive = ser_master;  val = ser_sclk; end
          3:       begin drive = ~ser_master; val = ser_rdy;  end
          default: ;
        endcase
      end
      pin    = shape(drive, val, OD_BITS[b]);
      oe[b]  = pin.oe;
      out[b] = pin.out;
    end
  end

endmodule

// File: rtl/nib_port_bank.sv
module nib_port_bank
  import nib_port_pkg::*;
#(
  parameter int           NPORT      = 5,
  parameter int           NIB        = 4,
  parameter int           AW         = 8,
  parameter int           BASE       = 'hB0,
  parameter int           STRIDE     = 4,
  parameter logic [4:0]   OD_GROUP   = 5'b00010,
  parameter int           SPLIT_PORT = 3,
  parameter logic [3:0]   OD_SPLIT   = 4'b0101,
  parameter int           SER_PORT   = 4,
  localparam int          NPIN       = NPORT * NIB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NIB-1:0]  bus_wdata,
  input  logic            bus_we,
  output logic [NIB-1:0]  bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_pu,
  input  logic            ser_en,
  input  logic            ser_master,
  input  logic            ser_sout,
  input  logic            ser_sclk_out,
  input  logic            ser_rdy_out,
  output logic            ser_sin,
  output logic            ser_sclk_in,
  output logic            ser_rdy_in
);

  localparam int SER_PIN = SER_PORT * NIB;

  dec_t           dec;
  logic           addr_hit;
  logic [NIB-1:0] dir_q [NPORT];
  logic [NIB-1:0] dat_q [NPORT];
  logic [NIB-1:0] pup_q [NPORT];
  logic [NPIN-1:0] od_pins;

  assign dec      = decode(int'(bus_addr), BASE, STRIDE, NPORT);
  assign addr_hit = dec.hit;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [NIB-1:0] ODB =
      (p == SPLIT_PORT) ? NIB'(OD_SPLIT) : {NIB{OD_GROUP[p]}};
    logic sel_wr;
    assign sel_wr = bus_we && dec.hit && (int'(dec.port) == p);

    nib_port_regs #(.NIB(NIB)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (sel_wr),
      .kind  (dec.kind),
      .wdata (bus_wdata),
      .dir_q (dir_q[p]),
      .dat_q (dat_q[p]),
      .pup_q (pup_q[p])
    );

    nib_pin_drive #(.NIB(NIB), .OD_BITS(ODB), .SER(p == SER_PORT)) u_drive (
      .dir        (dir_q[p]),
      .dat        (dat_q[p]),
      .ser_en     (ser_en),
      .ser_master (ser_master),
      .ser_sout   (ser_sout),
      .ser_sclk   (ser_sclk_out),
      .ser_rdy    (ser_rdy_out),
      .oe         (pad_oe[p*NIB +: NIB]),
      .out        (pad_out[p*NIB +: NIB])
    );

    assign pad_pu[p*NIB +: NIB]  = pup_q[p];
    assign od_pins[p*NIB +: NIB] = ODB;
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (dec.hit && int'(dec.port) == p) begin
        case (dec.kind)
          KIND_DIR: bus_rdata = dir_q[p];
          KIND_DAT: bus_rdata = merge_read(dir_q[p], dat_q[p], pad_in[p*NIB +: NIB]);
          KIND_PUP: bus_rdata = pup_q[p];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign ser_sin     = ser_en ? pad_in[SER_PIN]     : 1'b1;
  assign ser_sclk_in = ser_en ? pad_in[SER_PIN + 2] : 1'b1;
  assign ser_rdy_in  = ser_en ? pad_in[SER_PIN + 3] : 1'b1;

endmodule

// File: rtl/nib_port_bank_chk.sv
module nib_port_bank_chk #(
  parameter int         NPIN     = 20,
  parameter int         NIB      = 4,
  parameter int         AW       = 8,
  parameter int         BASE     = 'hB0,
  parameter logic [4:0] OD_GROUP = 5'b00010,
  parameter int         SER_PIN  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic [NIB-1:0]  bus_wdata,
  input logic            bus_we,
  input logic [NIB-1:0]  bus_rdata,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_pu,
  input logic [NPIN-1:0] od_pins,
  input logic            addr_hit,
  input logic            ser_en,
  input logic            ser_master
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !ser_en) |-> (pad_oe == '0 && pad_pu == '1)); // R1

  AST_PORT0_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) == BASE && !OD_GROUP[0]) |=>
      (pad_oe[NIB-1:0] == $past(bus_wdata))); // R3

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_out & od_pins) == '0)); // R4

  AST_SIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (!pad_oe[SER_PIN] && pad_oe[SER_PIN + 1])); // R7

  AST_SCLK_SLAVE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !ser_master) |-> !pad_oe[SER_PIN + 2]); // R8

  AST_RDY_MASTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && ser_master) |-> !pad_oe[SER_PIN + 3]); // R9

  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata == '0)); // R10

  AST_PU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pad_pu)); // R11

endmodule

bind nib_port_bank nib_port_bank_chk #(
  .NPIN(NPIN), .NIB(NIB), .AW(AW), .BASE(BASE), .OD_GROUP(OD_GROUP),
  .SER_PIN(SER_PORT * NIB)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_pu     (pad_pu),
  .od_pins    (od_pins),
  .addr_hit   (addr_hit),
  .ser_en     (ser_en),
  .ser_master (ser_master)
);

// File: tb/sim_nib_port_bank.sv
`timescale 1ns/1ps
module sim_nib_port_bank;

  localparam logic [4:0] GRP   = 5'b00010;
  localparam logic [3:0] SPLIT = 4'b0101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_rdata;
  logic [19:0] pad_in = 20'h5A3C6;
  logic [19:0] pad_oe, pad_out, pad_pu;
  logic        ser_en = 1'b0, ser_master = 1'b0, ser_sout = 1'b0;
  logic        ser_sclk_out = 1'b0, ser_rdy_out = 1'b0;
  logic        ser_sin, ser_sclk_in, ser_rdy_in;

  int nchk = 0;
  int nerr = 0;

  logic [3:0] m_dir [5];
  logic [3:0] m_dat [5];
  logic [3:0] m_pup [5];

  always #4 clk = ~clk;

  nib_port_bank #(.OD_GROUP(GRP), .OD_SPLIT(SPLIT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .ser_en(ser_en), .ser_master(ser_master),
    .ser_sout(ser_sout), .ser_sclk_out(ser_sclk_out), .ser_rdy_out(ser_rdy_out),
    .ser_sin(ser_sin), .ser_sclk_in(ser_sclk_in), .ser_rdy_in(ser_rdy_in)
  );

  // {we, addr, wdata, expected read}; pad_in = 5A3C6 throughout
  localparam int NV = 22;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'hB0, 4'h0, 4'h0},  // R1 direction reset
    {1'b0, 8'hB1, 4'h0, 4'h6},  // R6 all inputs -> pad
    {1'b0, 8'hB2, 4'h0, 4'hF},  // R1 pull-up reset
    {1'b1, 8'hB0, 4'hC, 4'h0},
    {1'b1, 8'hB1, 4'h9, 4'h0},
    {1'b0, 8'hB1, 4'h0, 4'hA},  // R6 mixed read
    {1'b0, 8'hB0, 4'h0, 4'hC},  // R2
    {1'b1, 8'hB6, 4'h3, 4'h0},
    {1'b0, 8'hB6, 4'h0, 4'h3},  // R2 pull-up port 1
    {1'b0, 8'hB4, 4'h0, 4'h0},  // R2 neighbour untouched
    {1'b0, 8'hB5, 4'h0, 4'hC},  // R6
    {1'b1, 8'hA0, 4'h7, 4'h0},
    {1'b0, 8'hA0, 4'h0, 4'h0},  // R10 below window
    {1'b1, 8'hB3, 4'h7, 4'h0},
    {1'b0, 8'hB3, 4'h0, 4'h0},  // R10 hole
    {1'b1, 8'hC3, 4'h7, 4'h0},
    {1'b0, 8'hC3, 4'h0, 4'h0},  // R10 hole last port
    {1'b0, 8'hC4, 4'h0, 4'h0},  // R10 above window
    {1'b1, 8'hC0, 4'h3, 4'h0},
    {1'b1, 8'hC1, 4'h2, 4'h0},
    {1'b0, 8'hC1, 4'h0, 4'h6},  // R6 port 4
    {1'b0, 8'hBA, 4'h0, 4'hF}   // R2 port 2 pull-up untouched
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < 5; p++) begin
      m_dir[p] = 4'h0; m_dat[p] = 4'hF; m_pup[p] = 4'hF;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    for (int p = 0; p < 5; p++) begin
      if (a == 8'hB0 + 8'(4 * p))     m_dir[p] = d;
      if (a == 8'hB0 + 8'(4 * p + 1)) m_dat[p] = d;
      if (a == 8'hB0 + 8'(4 * p + 2)) m_pup[p] = d;
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    chk(bus_rdata == e, $sformatf("%s read %h", tag, a), 32'(bus_rdata), 32'(e));
  endtask

  task automatic check_pins(input string tag);
    logic [19:0] eo, ev, ep;
    @(negedge clk);
    #1;
    for (int i = 0; i < 20; i++) begin
      int   p;
      int   b;
      logic d, v, od;
      p  = i / 4;
      b  = i % 4;
      d  = m_dir[p][b];
      v  = m_dat[p][b];
      od = (p == 3) ? SPLIT[b] : GRP[p];
      if (p == 4 && ser_en) begin
        if (b == 0)      begin d = 1'b0;        v = 1'b0;         end
        else if (b == 1) begin d = 1'b1;        v = ser_sout;     end
        else if (b == 2) begin d = ser_master;  v = ser_sclk_out; end
        else             begin d = !ser_master; v = ser_rdy_out;  end
      end
      eo[i] = od ? (d & !v) : d;
      ev[i] = od ? 1'b0 : v;
      ep[i] = m_pup[p][b];
    end
    chk(pad_oe == eo, {tag, " pad_oe"}, 32'(pad_oe), 32'(eo));
    chk((pad_out & eo) == (ev & eo), {tag, " pad_out"}, 32'(pad_out & eo), 32'(ev & eo));
    chk(pad_pu == ep, {tag, " pad_pu"}, 32'(pad_pu), 32'(ep));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_pins("R1 after reset");
    for (int p = 0; p < 5; p++) begin
      rd(8'hB0 + 8'(4 * p), 4'h0, "R1 R2 dir");
      rd(8'hB2 + 8'(4 * p), 4'hF, "R1 R2 pup");
    end

    // vector table: R2 R6 R10
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][16]) wr(VEC[k][15:8], VEC[k][7:4]);
      else rd(VEC[k][15:8], VEC[k][3:0], $sformatf("R2/R6/R10 table[%0d]", k));
    end
    check_pins("R10 after table");

    // R3 push-pull port 0
    wr(8'hB0, 4'hF); wr(8'hB1, 4'hA);
    check_pins("R3 push-pull");
    chk(pad_oe[3:0] == 4'hF && pad_out[3:0] == 4'hA, "R3 port0", 32'({pad_oe[3:0], pad_out[3:0]}), 32'h000000FA);

    // R4 open-drain port 1
    wr(8'hB4, 4'hF); wr(8'hB5, 4'h5);
    check_pins("R4 open-drain");
    chk(pad_oe[7:4] == 4'hA, "R4 port1 oe", 32'(pad_oe[7:4]), 32'hA);
    wr(8'hB5, 4'hF);
    check_pins("R4 all ones released");
    chk(pad_oe[7:4] == 4'h0, "R4 port1 released", 32'(pad_oe[7:4]), 32'h0);

    // R5 split group
    wr(8'hBC, 4'hF); wr(8'hBD, 4'h0);
    check_pins("R5 split data 0");
    wr(8'hBD, 4'hF);
    check_pins("R5 split data F");
    chk(pad_oe[15:12] == 4'hA, "R5 split oe", 32'(pad_oe[15:12]), 32'hA);

    // R11 pull-up output
    wr(8'hBA, 4'h5);
    check_pins("R11 pull-up");
    chk(pad_pu[11:8] == 4'h5, "R11 port2 pu", 32'(pad_pu[11:8]), 32'h5);

    // R7 serial inputs idle while disabled
    chk({ser_sin, ser_sclk_in, ser_rdy_in} == 3'b111, "R7 idle", 32'({ser_sin, ser_sclk_in, ser_rdy_in}), 32'h7);

    // serial handover with fighting register contents
    wr(8'hC0, 4'hF); wr(8'hC1, 4'h9);
    pad_in = 20'hA5C3A;
    ser_en = 1'b1; ser_master = 1'b1; ser_sout = 1'b1; ser_sclk_out = 1'b0; ser_rdy_out = 1'b1;
    check_pins("R7 R8 master");
    chk(pad_oe[19:16] == 4'b0110, "R8 R9 master oe", 32'(pad_oe[19:16]), 32'h6);
    chk(ser_sin == pad_in[16], "R7 sin", 32'(ser_sin), 32'(pad_in[16]));
    chk(ser_rdy_in == pad_in[19], "R9 rdy in", 32'(ser_rdy_in), 32'(pad_in[19]));
    ser_master = 1'b0; ser_sout = 1'b0; ser_rdy_out = 1'b0;
    check_pins("R8 R9 slave");
    chk(pad_oe[19:16] == 4'b1010, "R8 R9 slave oe", 32'(pad_oe[19:16]), 32'hA);
    chk(ser_sclk_in == pad_in[18], "R8 sclk in", 32'(ser_sclk_in), 32'(pad_in[18]));
    ser_en = 1'b0;
    check_pins("R7 released");

    // R1 reset after activity
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    check_pins("R1 re-reset");
    rd(8'hC1, pad_in[19:16], "R1 R6 data after reset");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule